// File: doc/BRIEF.md
# Multi-Mode Modulator Output Interface

This block sits between a one-bit delta-sigma modulator and the chip pins. It paces the modulator: once every two system clock cycles it raises an accept strobe and captures the modulator bit on that edge. It then presents the bit stream off-chip in one of four timing formats, chosen by a two-bit mode input. Three formats send a clock with the data: a clock at the modulator rate, a half-rate clock that the receiver samples on both edges, and a clock derived from an externally supplied system clock. The fourth is a single-wire Manchester stream with the clock outputs parked low. Every clock and data output has a registered complementary twin for differential or noise-immune transmission.

The oscillator is modelled as the system clock input, so all formats run in one clock domain and every output is a flop. The mode input is treated as asynchronous. It passes through a synchronizer, and any change of the synchronized mode restarts the phase counter so that the first bit in the new format has clean timing.

Top module: `mdi_top`

## Requirements
- R1: The mode input selects the format as 2'b00 modulator-rate clock, 2'b01 half-rate double-edge clock, 2'b10 Manchester with no clock, 2'b11 external-clock format.
- R2: `bit_take` is high for exactly one cycle in every two system cycles, and is high in the first cycle after a restart. `mod_bit` is captured on the clock edge that ends a `bit_take` cycle.
- R3: In mode 2'b00, `mclk_o` is low for one cycle and high for one cycle. It falls on the edge where `mdat_o` takes the new bit, so the data is stable across every rising edge of `mclk_o`.
- R4: In mode 2'b01, `mclk_o` has a period of four system cycles. `mdat_o` changes only on edges where `mclk_o` holds its value, and `mclk_o` changes only on edges where `mdat_o` holds its value.
- R5: In mode 2'b10, `mclk_o` and `mclk_on` are both low. Each bit lasts two cycles: a one is sent as low then high, and a zero as high then low.
- R6: In mode 2'b11, the clock output is half the system clock and the data updates on every other edge, with the same cycle relation as mode 2'b00.
- R7: `mdat_on` is always the inverse of `mdat_o`. Outside mode 2'b10, `mclk_on` is the inverse of `mclk_o`.
- R8: A mode change reaches the control logic after SYNC_STAGES clock edges. On the next edge the interface restarts: `bit_take` stays low, `mclk_o` goes low, and `mdat_o` holds its value.
- R9: While reset is held, `mclk_o`=0, `mclk_on`=1, `mdat_o`=0 and `mdat_on`=1. After reset the mode is 2'b00 with the phase at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (oscillator or external) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Asynchronous format select |
| mod_bit | input | 1 | Modulator output bit |
| bit_take | output | 1 | Accept strobe, one per modulator period |
| mclk_o | output | 1 | Output clock |
| mclk_on | output | 1 | Complement of output clock (low in Manchester) |
| mdat_o | output | 1 | Data or Manchester stream |
| mdat_on | output | 1 | Complement of data |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. This makes the restart latency exactly three edges after a pin change, and that latency is visible at the ports. The value also lets a one-cycle glitch on the mode pins pass through the synchronizer, which forces two back-to-back restarts. With a two-stage chain, the behavioural model can track mode changes issued mid-bit and mid-Manchester-symbol from every format into every other format, including a reset taken while Manchester is active.

// File: rtl/mdi_pkg.sv
package mdi_pkg;
   typedef enum logic [1:0] {
      OM_FULL  = 2'b00,
      OM_HALF  = 2'b01,
      OM_MANCH = 2'b10,
      OM_EXT   = 2'b11
   } omode_t;

   localparam int MODE_W = 2;
   localparam int PH_W   = 2;
endpackage

// File: rtl/mdi_mode_sync.sv
module mdi_mode_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("mdi_mode_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("mdi_mode_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[LAST];
endmodule

// File: rtl/mdi_phase.sv
module mdi_phase
   import mdi_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  omode_t          mode_in,
   output omode_t          mode_q,
   output logic [PH_W-1:0] ph,
   output logic            restart,
   output logic            take
);
   assign restart = (mode_in != mode_q);
   assign take    = !restart && !ph[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= OM_FULL;
         ph     <= '0;
      end else if (restart) begin
         mode_q <= mode_in;
         ph     <= '0;
      end else begin
         ph     <= ph + PH_W'(1);
      end
   end
endmodule

// File: rtl/mdi_format.sv
module mdi_format
   import mdi_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  omode_t          mode_q,
   input  omode_t          mode_in,
   input  logic [PH_W-1:0] ph,
   input  logic            restart,
   input  logic            take,
   input  logic            bit_in,
   output logic            clk_o,
   output logic            clk_on,
   output logic            dat_o,
   output logic            dat_on
);
   logic held;
   logic half_c;
   logic full_c;

   assign full_c = ph[0];
   assign half_c = ph[1] ^ ph[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_o  <= 1'b0;
         clk_on <= 1'b1;
         dat_o  <= 1'b0;
         dat_on <= 1'b1;
         held   <= 1'b0;
      end else if (restart) begin
         clk_o  <= 1'b0;
         clk_on <= (mode_in != OM_MANCH);
      end else begin
         unique case (mode_q)
            OM_FULL, OM_EXT: begin
               clk_o  <= full_c;
               clk_on <= !full_c;
               if (take) begin
                  dat_o  <= bit_in;
                  dat_on <= !bit_in;
                  held   <= bit_in;
               end
            end
            OM_HALF: begin
               clk_o  <= half_c;
               clk_on <= !half_c;
               if (take) begin
                  dat_o  <= bit_in;
                  dat_on <= !bit_in;
                  held   <= bit_in;
               end
            end
            OM_MANCH: begin
               clk_o  <= 1'b0;
               clk_on <= 1'b0;
               if (take) begin
                  dat_o  <= !bit_in;
                  dat_on <= bit_in;
                  held   <= bit_in;
               end else begin
                  dat_o  <= held;
                  dat_on <= !held;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/mdi_top.sv
module mdi_top
   import mdi_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_sel,
   input  logic       mod_bit,
   output logic       bit_take,
   output logic       mclk_o,
   output logic       mclk_on,
   output logic       mdat_o,
   output logic       mdat_on
);
   logic [MODE_W-1:0] mode_s_w;
   omode_t            mode_in;
   omode_t            mode_q_w;
   logic [PH_W-1:0]   ph_w;
   logic              restart_w;

   mdi_mode_sync #(.STAGES(SYNC_STAGES), .W(MODE_W)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mode_sel),
      .q     (mode_s_w)
   );

   assign mode_in = omode_t'(mode_s_w);

   mdi_phase i_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_in (mode_in),
      .mode_q  (mode_q_w),
      .ph      (ph_w),
      .restart (restart_w),
      .take    (bit_take)
   );

   mdi_format i_format (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_q  (mode_q_w),
      .mode_in (mode_in),
      .ph      (ph_w),
      .restart (restart_w),
      .take    (bit_take),
      .bit_in  (mod_bit),
      .clk_o   (mclk_o),
      .clk_on  (mclk_on),
      .dat_o   (mdat_o),
      .dat_on  (mdat_on)
   );
endmodule

// File: rtl/mdi_chk.sv
module mdi_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_q,
   input logic [1:0] mode_s,
   input logic       take,
   input logic       mclk_o,
   input logic       mclk_on,
   input logic       mdat_o,
   input logic       mdat_on
);
   // R2: the accept strobe never holds for two cycles
   a_r2_take_single: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   // R7: the data twin is always the inverse
   a_r7_dat_twin: assert property (@(posedge clk) disable iff (!rst_n)
      mdat_on != mdat_o);

   // R5: in steady Manchester both clock outputs are low
   a_r5_manch_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b10 && mode_s == 2'b10) |=> (!mclk_o && !mclk_on));

   // R3 and R6: data moves only when the output clock is low
   a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'b00 || mode_q == 2'b11) && !$stable(mdat_o)) |-> !mclk_o);

   // R4: data and clock edges never coincide in half-rate format
   a_r4_edges_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && !$stable(mdat_o)) |-> $stable(mclk_o));

   // R8: a pending mode change parks the clock low on the next edge
   a_r8_restart_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != mode_s) |=> !mclk_o);
endmodule

bind mdi_top mdi_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_q  (mode_q_w),
   .mode_s  (mode_s_w),
   .take    (bit_take),
   .mclk_o  (mclk_o),
   .mclk_on (mclk_on),
   .mdat_o  (mdat_o),
   .mdat_on (mdat_on)
);

// File: tb/test_mdi_top.sv
module test_mdi_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       mod_bit = 1'b0;
   logic       bit_take, mclk_o, mclk_on, mdat_o, mdat_on;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   mdi_top #(.SYNC_STAGES(2)) i_mdi_top (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mod_bit(mod_bit),
      .bit_take(bit_take), .mclk_o(mclk_o), .mclk_on(mclk_on),
      .mdat_o(mdat_o), .mdat_on(mdat_on)
   );

   // behavioural reference model
   int s1 = 0, s2 = 0, cur = 0, ph = 0;
   bit e_clk = 0, e_clkn = 1, e_dat = 0, e_datn = 1, hb = 0;
   bit last_rs = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         s1 = 0; s2 = 0; cur = 0; ph = 0;
         e_clk = 0; e_clkn = 1; e_dat = 0; e_datn = 1; hb = 0; last_rs = 0;
      end else begin
         if (s2 != cur) begin
            cur = s2; ph = 0; e_clk = 0; e_clkn = (s2 != 2); last_rs = 1;
         end else begin
            bit tk;
            tk = (ph % 2 == 0);
            last_rs = 0;
            if (cur == 2) begin
               e_clk = 0; e_clkn = 0;
               if (tk) begin e_dat = !mod_bit; hb = mod_bit; end
               else e_dat = hb;
            end else begin
               if (cur == 1) e_clk = (ph == 1 || ph == 2);
               else          e_clk = (ph == 1 || ph == 3);
               e_clkn = !e_clk;
               if (tk) begin e_dat = mod_bit; hb = mod_bit; end
            end
            ph = (ph + 1) % 4;
         end
         e_datn = !e_dat;
         s2 = s1; s1 = int'(mode_sel);
      end
   end

   task automatic chk(string tag, string nm, logic act, bit exp);
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         string tg;
         bit e_take;
         vectors++;
         if (!rst_n)       tg = "R9";
         else if (last_rs) tg = "R8";
         else case (cur)
            0: tg = "R3";
            1: tg = "R4";
            2: tg = "R5";
            default: tg = "R6";
         endcase
         e_take = (s2 == cur) && (ph % 2 == 0);
         chk("R2", "bit_take", bit_take, e_take);
         chk({tg, " R1"}, "mclk_o", mclk_o, e_clk);
         chk(tg, "mdat_o", mdat_o, e_dat);
         chk((cur == 2 || !rst_n) ? tg : "R7", "mclk_on", mclk_on, e_clkn);
         chk("R7", "mdat_on", mdat_on, e_datn);
      end
   end

   task automatic run(int md, int n, int pat);
      mode_sel = md[1:0];
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         case (pat)
            0: mod_bit = $urandom_range(0, 1) == 1;
            1: mod_bit = 1'b1;
            2: mod_bit = 1'b0;
            default: mod_bit = (i % 4) < 2;
         endcase
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);          // R9 reset state
      rst_n = 1'b1;
      run(0, 60, 0); run(0, 20, 1); run(0, 20, 2); run(0, 20, 3);
      run(1, 80, 0); run(1, 24, 3);
      run(2, 80, 0); run(2, 20, 1); run(2, 20, 2); run(2, 24, 3);
      run(3, 80, 0); run(3, 20, 3);
      run(2, 5, 0); run(0, 7, 0); run(1, 3, 0); run(2, 9, 0);   // R8 mid-bit changes
      run(3, 1, 0); run(1, 30, 0);                              // glitch pulse
      run(2, 15, 0);
      @(negedge clk) rst_n = 1'b0;                              // reset in Manchester
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(2, 40, 0); run(0, 40, 0);
      @(negedge clk);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         misses++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule